// File: doc/BRIEF.md
# Chained TLB DMA Address Translator

This block translates the addresses of DMA requests in a second stage, using mappings held entirely in registers. There is no page-table walker. A register array holds `NUM_TLB` TLBs of `NUM_ENT` entries each. Every entry maps one page from a 48-bit virtual base to a 48-bit physical base. Each entry has its own page size, chosen from eight coded sizes between 4 KB and 16 GB, and its own user and supervisor read/write/execute permissions.

A request carries a virtual ID, an address, an access type and a privilege bit. The virtual ID names the root TLB directly: TLBs 0 to `MAX_VID` are the roots. The controller examines one TLB per clock cycle. If that TLB holds no matching entry, the controller follows the TLB's chain pointer to a higher-numbered TLB. The walk ends with a translated address, or it ends with a fault that reports the virtual ID and the original address.

Software programs the entries, the per-TLB control words and a global enable through a simple word write port. The mappings are intended to be loaded once, before traffic starts.

Top module: `chain_xlate`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspValid` is 0. The global enable is off and every TLB is disabled, so the first request after reset faults.
- R2: While the global enable is 0, every request returns `rspFault`=1 after a single walk step. The global enable is written with word code 5, and data bit 0 holds the enable value.
- R3: The virtual ID selects root TLB number `reqVid`. If the enable bit of the TLB being visited is 0, the walk ends with a fault.
- R4: An entry is valid only when its attribute bits 31:30 equal 2. A valid entry matches when (address − virtual base) is less than the page size given by attribute bits 19:16. The codes 0 to 7 map to 4K, 16K, 64K, 2M, 32M, 512M, 1G and 16G. Codes 8 to 15 never match.
- R5: On a hit with permission, `rspAddr` is the physical base plus the offset. On any fault, `rspAddr` is the request address. `rspVid` always echoes the request's virtual ID.
- R6: Permission bits sit in the attribute word. User read, write and execute are bits 15, 14 and 13. Supervisor read, write and execute are bits 12, 11 and 10. `reqSup` selects the supervisor set. `reqAcc` takes 0 for read, 1 for write and 2 for execute. `reqAcc`=3, or a missing permission bit on the hitting entry, gives a fault, and no further TLB is searched.
- R7: A TLB control word holds the enable at bit 31 and the next-TLB pointer at bits 11:0. The walk moves on only when the pointer is greater than the current TLB, greater than `MAX_VID` and less than `NUM_TLB`. Any other pointer value, including 0, ends the walk with a fault.
- R8: The controller examines one TLB per cycle. Suppose a request is accepted on a clock edge (`reqValid` and `reqReady` both 1) and the walk visits d TLBs. Then `rspValid` is 1 for exactly one cycle, starting d edges later, and `reqReady` stays 0 in between.
- R9: Within one TLB, the lowest-numbered matching entry decides the result. Along a chain, an earlier TLB decides before a later one.
- R10: The write port uses word codes for one entry: 0 writes virtual base bits 31:0, 1 writes bits 47:32 from data 15:0, 2 writes attributes, 3 writes physical base bits 31:0 and 4 writes physical bits 47:32 from data 15:0. Code 7 writes the TLB control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqVid | input | VID_W (3) | Virtual ID / root TLB |
| reqAddr | input | 48 | Input address |
| reqAcc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| reqSup | input | 1 | Supervisor access |
| reqReady | output | 1 | Translator idle, request accepted |
| rspValid | output | 1 | One-cycle response strobe |
| rspFault | output | 1 | Response is a fault |
| rspVid | output | VID_W (3) | Virtual ID of the response |
| rspAddr | output | 48 | Translated address, or faulting address |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrTlb | input | TLB_W (4) | Target TLB |
| cfgWrEnt | input | ENT_W (3) | Target entry |
| cfgWrWord | input | 3 | Word code (see R10, R2) |
| cfgWrData | input | 32 | Write data |

## Verification
A reference walk in the bench computes the expected fault flag, address and step count for every request. Directed requests test the following cases:
- A page boundary, where the last byte hits and the next byte moves on.
- Overlapping entries, where the lower index must win even when it denies the access.
- Invalid mode values and size codes above 7.
- Disabled roots and disabled chained TLBs.
- Backward and self-pointing chain links.
- A three-TLB chain with a 16 GB page.

Random traffic then aims at addresses around random entry bases, with random access types and privileges. This mix separates hits from misses that fall just past a page. It also separates permission faults from chain-end faults. The step count tells whether the chain was actually followed or the walk ended early.

// File: rtl/chain_xlate_pkg.sv
package chain_xlate_pkg;
  localparam int ADDR_W = 48;

  localparam logic [2:0] W_VLO    = 3'd0;
  localparam logic [2:0] W_VHI    = 3'd1;
  localparam logic [2:0] W_ATTR   = 3'd2;
  localparam logic [2:0] W_PLO    = 3'd3;
  localparam logic [2:0] W_PHI    = 3'd4;
  localparam logic [2:0] W_GLOBAL = 3'd5;
  localparam logic [2:0] W_CTL    = 3'd7;

  localparam logic [1:0] MODE_VALID = 2'b10;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] code;
    logic [5:0] perm;  // {uR,uW,uX,sR,sW,sX}
  } attr_t;

  typedef struct packed {
    logic        en;
    logic [11:0] next;
  } ctl_t;

  typedef struct packed {
    logic capture;
    logic step;
    logic finish;
    logic fault;
  } strobe_t;

  typedef struct packed {
    logic tlbOn;
    logic hit;
    logic permOk;
    logic chainOk;
  } status_t;

  function automatic int pageShift(input logic [3:0] code);
    case (code)
      4'd0: return 12;
      4'd1: return 14;
      4'd2: return 16;
      4'd3: return 21;
      4'd4: return 25;
      4'd5: return 29;
      4'd6: return 30;
      4'd7: return 34;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/chain_xlate_regs.sv
module chain_xlate_regs
  import chain_xlate_pkg::*;
#(
  parameter int NUM_TLB = 16,
  parameter int NUM_ENT = 8,
  localparam int TLB_W = $clog2(NUM_TLB),
  localparam int ENT_W = $clog2(NUM_ENT)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wrEn,
  input  logic [TLB_W-1:0]                wrTlb,
  input  logic [ENT_W-1:0]                wrEnt,
  input  logic [2:0]                      wrWord,
  input  logic [31:0]                     wrData,
  input  logic [TLB_W-1:0]                rdTlb,
  output logic [NUM_ENT-1:0][ADDR_W-1:0]  rowV,
  output logic [NUM_ENT-1:0][ADDR_W-1:0]  rowP,
  output attr_t [NUM_ENT-1:0]             rowA,
  output ctl_t                            rowCtl,
  output logic                            globalEn
);
  logic [NUM_ENT-1:0][ADDR_W-1:0] vBase [NUM_TLB];
  logic [NUM_ENT-1:0][ADDR_W-1:0] pBase [NUM_TLB];
  attr_t [NUM_ENT-1:0]            attr  [NUM_TLB];
  ctl_t                           ctl   [NUM_TLB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      globalEn <= 1'b0;
      for (int t = 0; t < NUM_TLB; t++) begin
        ctl[t]   <= '0;
        vBase[t] <= '0;
        pBase[t] <= '0;
        attr[t]  <= '0;
      end
    end else if (wrEn) begin
      case (wrWord)
        W_VLO:    vBase[wrTlb][wrEnt][31:0]  <= wrData;
        W_VHI:    vBase[wrTlb][wrEnt][47:32] <= wrData[15:0];
        W_ATTR:   attr[wrTlb][wrEnt] <= {wrData[31:30], wrData[19:16], wrData[15:10]};
        W_PLO:    pBase[wrTlb][wrEnt][31:0]  <= wrData;
        W_PHI:    pBase[wrTlb][wrEnt][47:32] <= wrData[15:0];
        W_GLOBAL: globalEn <= wrData[0];
        W_CTL:    ctl[wrTlb] <= {wrData[31], wrData[11:0]};
        default: ;
      endcase
    end
  end

  assign rowV   = vBase[rdTlb];
  assign rowP   = pBase[rdTlb];
  assign rowA   = attr[rdTlb];
  assign rowCtl = ctl[rdTlb];
endmodule

// File: rtl/chain_xlate_path.sv
module chain_xlate_path
  import chain_xlate_pkg::*;
#(
  parameter int NUM_TLB = 16,
  parameter int NUM_ENT = 8,
  parameter int MAX_VID = 7,
  localparam int TLB_W = $clog2(NUM_TLB),
  localparam int VID_W = $clog2(MAX_VID + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  strobe_t                         stb,
  input  logic [VID_W-1:0]                reqVid,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [1:0]                      reqAcc,
  input  logic                            reqSup,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0]  rowV,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0]  rowP,
  input  attr_t [NUM_ENT-1:0]             rowA,
  input  ctl_t                            rowCtl,
  output logic [TLB_W-1:0]                curTlb,
  output status_t                         status,
  output logic                            rspValid,
  output logic                            rspFault,
  output logic [VID_W-1:0]                rspVid,
  output logic [ADDR_W-1:0]               rspAddr
);
  logic [VID_W-1:0]               vidQ;
  logic [ADDR_W-1:0]              addrQ;
  logic [1:0]                     accQ;
  logic                           supQ;
  logic [NUM_ENT-1:0][ADDR_W-1:0] offs;
  logic [NUM_ENT-1:0]             hitVec;
  logic [ADDR_W-1:0]              hitPhys;
  attr_t                          hitAttr;
  logic                           anyHit;
  logic [2:0]                     permIdx;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign offs[e]   = addrQ - rowV[e];
    assign hitVec[e] = (rowA[e].mode == MODE_VALID) && !rowA[e].code[3] &&
                       ((offs[e] >> pageShift(rowA[e].code)) == '0);
  end

  always_comb begin
    anyHit  = 1'b0;
    hitPhys = '0;
    hitAttr = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (hitVec[e]) begin
        anyHit  = 1'b1;
        hitPhys = rowP[e] + offs[e];
        hitAttr = rowA[e];
      end
    end
  end

  assign permIdx = supQ ? (3'd2 - {1'b0, accQ}) : (3'd5 - {1'b0, accQ});

  assign status.tlbOn   = rowCtl.en;
  assign status.hit     = anyHit;
  assign status.permOk  = (accQ != 2'd3) && hitAttr.perm[permIdx];
  assign status.chainOk = (rowCtl.next > 12'(curTlb)) &&
                          (rowCtl.next > 12'(MAX_VID)) &&
                          (rowCtl.next < 12'(NUM_TLB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vidQ     <= '0;
      addrQ    <= '0;
      accQ     <= '0;
      supQ     <= 1'b0;
      curTlb   <= '0;
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspVid   <= '0;
      rspAddr  <= '0;
    end else begin
      rspValid <= stb.finish;
      if (stb.capture) begin
        vidQ   <= reqVid;
        addrQ  <= reqAddr;
        accQ   <= reqAcc;
        supQ   <= reqSup;
        curTlb <= TLB_W'(reqVid);
      end
      if (stb.step) curTlb <= rowCtl.next[TLB_W-1:0];
      if (stb.finish) begin
        rspFault <= stb.fault;
        rspVid   <= vidQ;
        rspAddr  <= stb.fault ? addrQ : hitPhys;
      end
    end
  end
endmodule

// File: rtl/chain_xlate_ctrl.sv
module chain_xlate_ctrl
  import chain_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    globalEn,
  input  status_t status,
  output strobe_t stb,
  output logic    reqReady
);
  typedef enum logic {S_IDLE, S_WALK} state_t;
  state_t state;

  always_comb begin
    stb = '0;
    if (state == S_IDLE) begin
      stb.capture = reqValid;
    end else if (!globalEn || !status.tlbOn) begin
      stb.finish = 1'b1;
      stb.fault  = 1'b1;
    end else if (status.hit) begin
      stb.finish = 1'b1;
      stb.fault  = !status.permOk;
    end else if (status.chainOk) begin
      stb.step = 1'b1;
    end else begin
      stb.finish = 1'b1;
      stb.fault  = 1'b1;
    end
  end

  assign reqReady = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else if (stb.capture) state <= S_WALK;
    else if (stb.finish) state <= S_IDLE;
  end
endmodule

// File: rtl/chain_xlate.sv
module chain_xlate
  import chain_xlate_pkg::*;
#(
  parameter int NUM_TLB = 16,
  parameter int NUM_ENT = 8,
  parameter int MAX_VID = 7,
  localparam int TLB_W = $clog2(NUM_TLB),
  localparam int ENT_W = $clog2(NUM_ENT),
  localparam int VID_W = $clog2(MAX_VID + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [VID_W-1:0]  reqVid,
  input  logic [47:0]       reqAddr,
  input  logic [1:0]        reqAcc,
  input  logic              reqSup,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspFault,
  output logic [VID_W-1:0]  rspVid,
  output logic [47:0]       rspAddr,
  input  logic              cfgWrEn,
  input  logic [TLB_W-1:0]  cfgWrTlb,
  input  logic [ENT_W-1:0]  cfgWrEnt,
  input  logic [2:0]        cfgWrWord,
  input  logic [31:0]       cfgWrData
);
  logic [NUM_ENT-1:0][ADDR_W-1:0] rowV, rowP;
  attr_t [NUM_ENT-1:0]            rowA;
  ctl_t                           rowCtl;
  logic                           globalEn;
  logic [TLB_W-1:0]               curTlb;
  strobe_t                        stb;
  status_t                        status;

  chain_xlate_regs #(.NUM_TLB(NUM_TLB), .NUM_ENT(NUM_ENT)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wrEn(cfgWrEn), .wrTlb(cfgWrTlb), .wrEnt(cfgWrEnt),
    .wrWord(cfgWrWord), .wrData(cfgWrData),
    .rdTlb(curTlb), .rowV(rowV), .rowP(rowP), .rowA(rowA),
    .rowCtl(rowCtl), .globalEn(globalEn)
  );

  chain_xlate_path #(.NUM_TLB(NUM_TLB), .NUM_ENT(NUM_ENT), .MAX_VID(MAX_VID)) path_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .reqVid(reqVid), .reqAddr(reqAddr), .reqAcc(reqAcc), .reqSup(reqSup),
    .rowV(rowV), .rowP(rowP), .rowA(rowA), .rowCtl(rowCtl),
    .curTlb(curTlb), .status(status),
    .rspValid(rspValid), .rspFault(rspFault), .rspVid(rspVid), .rspAddr(rspAddr)
  );

  chain_xlate_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .globalEn(globalEn),
    .status(status), .stb(stb), .reqReady(reqReady)
  );
endmodule

// File: rtl/chain_xlate_chk.sv
module chain_xlate_chk (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic reqReady,
  input logic rspValid,
  input logic rspFault,
  input logic globalEn
);
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

  // R8
  rsp_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $past(!reqReady));

  // R8
  idle_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> reqReady);

  // R2
  disabled_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !$past(globalEn) |-> rspFault);
endmodule

bind chain_xlate chain_xlate_chk chk_i (.*);

// File: tb/chain_xlate_tb_top.sv
module chain_xlate_tb_top;
  localparam int NT = 16;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqVid = '0;
  logic [47:0] reqAddr = '0;
  logic [1:0]  reqAcc = '0;
  logic        reqSup = 1'b0;
  logic        reqReady, rspValid, rspFault;
  logic [2:0]  rspVid;
  logic [47:0] rspAddr;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrTlb = '0;
  logic [2:0]  cfgWrEnt = '0;
  logic [2:0]  cfgWrWord = '0;
  logic [31:0] cfgWrData = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [47:0] mV [NT][NE];
  logic [47:0] mP [NT][NE];
  logic [31:0] mA [NT][NE];
  logic [31:0] mC [NT];
  bit          mG;

  always #10 clk = ~clk;

  chain_xlate dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int t, int e, logic [2:0] w, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgWrTlb = 4'(t); cfgWrEnt = 3'(e); cfgWrWord = w; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic wrEntry(int t, int e, logic [47:0] v, logic [47:0] p, logic [31:0] a);
    wr(t, e, 3'd0, v[31:0]);
    wr(t, e, 3'd1, {16'h0, v[47:32]});
    wr(t, e, 3'd2, a);
    wr(t, e, 3'd3, p[31:0]);
    wr(t, e, 3'd4, {16'h0, p[47:32]});
    mV[t][e] = v; mP[t][e] = p; mA[t][e] = a;
  endtask

  task automatic wrCtl(int t, bit en, logic [11:0] nxt);
    wr(t, 0, 3'd7, {en, 19'h0, nxt});
    mC[t] = {en, 19'h0, nxt};
  endtask

  task automatic setGlobal(bit en);
    wr(0, 0, 3'd5, {31'h0, en});
    mG = en;
  endtask

  function automatic int shOf(logic [3:0] c);
    case (c)
      0: return 12; 1: return 14; 2: return 16; 3: return 21;
      4: return 25; 5: return 29; 6: return 30; 7: return 34;
      default: return -1;
    endcase
  endfunction

  function automatic void model(int vid, logic [47:0] a, int acc, bit sup,
                                output bit f, output logic [47:0] o, output int steps);
    int cur = vid;
    f = 1; o = a; steps = 0;
    forever begin
      steps++;
      if (!mG || !mC[cur][31]) return;
      for (int e = 0; e < NE; e++) begin
        logic [47:0] off = a - mV[cur][e];
        int sh = shOf(mA[cur][e][19:16]);
        if (mA[cur][e][31:30] == 2'd2 && sh >= 0 && (off >> sh) == 0) begin
          int bitNo = (sup ? 12 : 15) - acc;
          bit ok = (acc != 3) && mA[cur][e][bitNo];
          f = !ok;
          o = ok ? mP[cur][e] + off : a;
          return;
        end
      end
      begin
        int nxt = int'(mC[cur][11:0]);
        if (!(nxt > cur && nxt > 7 && nxt < NT)) return;
        cur = nxt;
      end
    end
  endfunction

  task automatic issue(string req, int vid, logic [47:0] a, int acc, bit sup);
    bit ef; logic [47:0] eo; int es; int n;
    model(vid, a, acc, sup, ef, eo, es);
    @(negedge clk);
    reqValid = 1; reqVid = 3'(vid); reqAddr = a; reqAcc = 2'(acc); reqSup = sup;
    @(negedge clk);
    reqValid = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rspValid && n < 64);
    check({req, " fault"}, 64'(rspFault), 64'(ef));
    check({req, " addr"}, 64'(rspAddr), 64'(eo));
    check({req, " vid"}, 64'(rspVid), 64'(vid));
    check({req, " R8 latency"}, 64'(n), 64'(es));
  endtask

  function automatic logic [31:0] mkAttr(logic [1:0] mode, logic [3:0] code, logic [5:0] perm);
    return {mode, 10'h0, code, perm, 10'h0};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int t = 0; t < NT; t++) begin
      mC[t] = 0;
      for (int e = 0; e < NE; e++) begin
        mV[t][e] = 0; mP[t][e] = 0; mA[t][e] = 0;
      end
    end
    mG = 0;
    repeat (3) @(negedge clk);
    check("R1 ready at reset", 64'(reqReady), 64'd1);
    check("R1 no rsp at reset", 64'(rspValid), 64'd0);
    rst_n = 1;
    // R1: everything off after reset
    issue("R1 first request", 0, 48'h1234, 0, 0);

    // random background entries in a high region
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < NE; e++) begin
        logic [3:0] code = ($urandom % 10 == 0) ? 4'd9 : 4'($urandom % 8);
        int sh = (shOf(code) < 0) ? 12 : shOf(code);
        logic [47:0] msk = ~((48'h1 << sh) - 1);
        logic [47:0] v = {4'hF, 44'({$urandom, $urandom})} & msk;
        logic [47:0] p = 48'({$urandom, $urandom}) & msk;
        logic [1:0] mode = ($urandom % 8 == 0) ? 2'(1 + 2 * ($urandom % 2)) : 2'd2;
        wrEntry(t, e, v, p, mkAttr(mode, code, 6'($urandom)));
      end
    // R7 chain layout
    wrCtl(0, 1, 12'd8);  wrCtl(8, 1, 12'd9);  wrCtl(9, 1, 12'd0);
    wrCtl(1, 0, 12'd0);
    wrCtl(2, 1, 12'd1);
    wrCtl(3, 1, 12'd10); wrCtl(10, 1, 12'd10);
    wrCtl(4, 1, 12'd11); wrCtl(11, 0, 12'd12);
    wrCtl(5, 1, 12'd12); wrCtl(12, 1, 12'd20);
    wrCtl(6, 1, 12'd13); wrCtl(13, 1, 12'd15); wrCtl(15, 1, 12'd0);
    wrCtl(7, 1, 12'd0);

    // R2 global enable off
    issue("R2 global off", 0, 48'h1000_0000, 0, 0);

    // R10 R4 R9 directed entries in TLB0
    wrEntry(0, 0, 48'h1000_0000, 48'h2000_0000, mkAttr(2'd2, 4'd0, 6'b100000));
    wrEntry(0, 1, 48'h1000_0000, 48'h3000_0000, mkAttr(2'd2, 4'd3, 6'b111111));
    wrEntry(0, 2, 48'h5000_0000, 48'h6000_0000, mkAttr(2'd2, 4'd9, 6'b111111));
    wrEntry(0, 3, 48'h7000_0000, 48'h6000_0000, mkAttr(2'd3, 4'd0, 6'b111111));
    wrEntry(9, 5, 48'h0008_0000_0000, 48'h0010_0000_0000, mkAttr(2'd2, 4'd7, 6'b111111));
    setGlobal(1);

    issue("R4 R9 last byte of 4K page", 0, 48'h1000_0FFF, 0, 0);
    check("R5 translated", 64'(rspAddr), 64'h2000_0FFF);
    issue("R4 next byte past 4K", 0, 48'h1000_1000, 0, 0);
    check("R5 via 2M entry", 64'(rspAddr), 64'h3000_1000);
    issue("R6 R9 write denied by lower entry", 0, 48'h1000_0010, 1, 0);
    issue("R6 supervisor read denied", 0, 48'h1000_0010, 0, 1);
    issue("R6 access code 3", 0, 48'h1000_1010, 3, 0);
    issue("R6 supervisor exec allowed", 0, 48'h1000_1010, 2, 1);
    issue("R4 size code 9 never matches", 0, 48'h5000_0000, 0, 0);
    issue("R4 mode 3 invalid", 0, 48'h7000_0000, 0, 0);
    issue("R7 R8 third TLB 16G page", 0, 48'h000B_FFFF_FFFF, 0, 0);
    check("R7 chained hit", 64'(rspFault), 64'd0);
    issue("R3 root disabled", 1, 48'h1000_0000, 0, 0);
    issue("R7 backward chain ends", 2, 48'h1000_0000, 0, 0);
    issue("R7 self chain ends", 3, 48'h1000_0000, 0, 0);
    issue("R3 chained TLB disabled", 4, 48'h1000_0000, 0, 0);
    issue("R7 pointer beyond array", 5, 48'h1000_0000, 0, 0);
    issue("R8 three step miss", 6, 48'h1000_0000, 0, 0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int vid = $urandom % 8;
      int t = $urandom % NT;
      int e = $urandom % NE;
      int sh = shOf(mA[t][e][19:16]);
      logic [47:0] a;
      if (sh < 0) sh = 12;
      a = mV[t][e] + (48'({$urandom, $urandom}) & ((48'h1 << (sh + 1)) - 1));
      if ($urandom % 8 == 0) a = 48'({$urandom, $urandom});
      issue("R4 R5 R6 R7 R9 random", vid, a, $urandom % 4, 1'($urandom));
    end

    // R2 disable again
    setGlobal(0);
    issue("R2 global off again", 0, 48'h1000_0FFF, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule